// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller Slice

This block gathers thirty-two interrupt request lines and turns them into two processor-facing requests: an ordinary one and a critical one. Every line has its own sense configuration: it can be taken as a level or as an edge, active high (rising) or active low (falling). A qualifying condition latches a pending bit, and software acknowledges it by writing a one to that bit. Pending bits are recorded whether or not the line is enabled, so a request that arrives while masked is still seen once software unmasks it.

Software reaches six registers through a single-cycle write strobe and a combinational read port. Register bits run in reverse interrupt order: request line n lives in bit 31-n. A line configured as a level keeps re-latching its pending bit for as long as its source is held active, so an acknowledge while the source is still active leaves the bit set.

Top module: `irq_ctrl_slice`

## Requirements
- R1: Request line src_i[n] is reported in bit 31-n of the pending, enable, routing, sense and mode registers, so line 0 is bit 31.
- R2: A mode bit of 1 makes the line edge sensitive: one qualifying transition sets the pending bit once, and the bit does not set again after an acknowledge while the input holds still. An input change is seen in the pending register two clock edges after it is applied, not one.
- R3: A sense bit of 1 selects active-high (rising edge) and 0 selects active-low (falling edge) for that line.
- R4: Writing address 0 (pending) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: Reading address 5 returns the pending register ANDed with the enable register (address 1).
- R6: irq_o is high when some pending and enabled bit has routing bit 0; crit_irq_o is high when some pending and enabled bit has routing bit 1 (routing register at address 2).
- R7: A line in level mode (mode bit 0, mode register at address 4) whose source stays active has its pending bit set again after an acknowledge.
- R8: Pending bits latch while the line is disabled, and enabling the line afterwards raises the output without a new input event.
- R9: When hardware sets a pending bit in the same cycle that software clears it, the bit ends up set.
- R10: After reset the pending, enable and routing registers read 0, the sense register (address 3) reads all ones, the mode register reads 0, and both outputs are low.
- R11: Enable, routing, sense and mode registers read back what was written; writes to address 5 have no effect, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw request lines, index n is line n |
| reg_we_i | input | 1 | Single-cycle register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Non-critical interrupt request |
| crit_irq_o | output | 1 | Critical interrupt request |

## Verification
The table drives level-mode patterns that separate the bit reversal (single lines at both ends of the vector), active-low sensing on all lines, a split sense register where half the lines are inverted, an enable mask that covers none of the pending bits, and a routing mask that moves all active lines to the critical output. Directed sequences then single out edge behaviour against level behaviour on one line: one transition latches once and stays cleared, while the same held source in level mode re-latches straight through an acknowledge. A falling-edge case and an acknowledge landing on the very cycle an edge is latched show the sense inversion and the set-over-clear priority, and a reset applied mid-run shows the register defaults.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NUM_SRC = 32;
  localparam int unsigned ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PEND  = 3'd0,
    ADDR_ENA   = 3'd1,
    ADDR_ROUTE = 3'd2,
    ADDR_SENSE = 3'd3,
    ADDR_MODE  = 3'd4,
    ADDR_MPEND = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] sense_i,
  input  logic [N-1:0] mode_i,
  output logic [N-1:0] set_o
);
  logic [N-1:0] smp_q;
  logic [N-1:0] act;
  logic [N-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      act_q <= '0;
    end else begin
      smp_q <= raw_i;
      act_q <= act;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign act[i]   = sense_i[i] ? smp_q[i] : ~smp_q[i];
    // mode 1: edge, mode 0: level
    assign set_o[i] = mode_i[i] ? (act[i] & ~act_q[i]) : act[i];
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] clr;

  assign clr = clr_en_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | set_i; // set wins over clear
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      ena_o,
  output logic [N-1:0]      route_o,
  output logic [N-1:0]      sense_o,
  output logic [N-1:0]      mode_o,
  output logic              pend_clr_o,
  output logic [N-1:0]      rdata_o
);
  reg_addr_e    a;
  logic [N-1:0] ena_q, route_q, sense_q, mode_q;

  assign a = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q   <= '0;
      route_q <= '0;
      sense_q <= '1;
      mode_q  <= '0;
    end else if (we_i) begin
      case (a)
        ADDR_ENA:   ena_q   <= wdata_i;
        ADDR_ROUTE: route_q <= wdata_i;
        ADDR_SENSE: sense_q <= wdata_i;
        ADDR_MODE:  mode_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign pend_clr_o = we_i && (a == ADDR_PEND);

  always_comb begin
    case (a)
      ADDR_PEND:  rdata_o = pend_i;
      ADDR_ENA:   rdata_o = ena_q;
      ADDR_ROUTE: rdata_o = route_q;
      ADDR_SENSE: rdata_o = sense_q;
      ADDR_MODE:  rdata_o = mode_q;
      ADDR_MPEND: rdata_o = pend_i & ena_q;
      default:    rdata_o = '0;
    endcase
  end

  assign ena_o   = ena_q;
  assign route_o = route_q;
  assign sense_o = sense_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/irq_out_route.sv
module irq_out_route #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] ena_i,
  input  logic [N-1:0] route_i,
  output logic         irq_o,
  output logic         crit_irq_o
);
  logic [N-1:0] live;
  assign live       = pend_i & ena_i;
  assign irq_o      = |(live & ~route_i);
  assign crit_irq_o = |(live & route_i);
endmodule

// File: rtl/irq_ctrl_slice.sv
module irq_ctrl_slice
  import irq_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic               irq_o,
  output logic               crit_irq_o
);
  localparam int unsigned N = NUM_SRC;

  logic [N-1:0] src_rev, set_vec, pend_q;
  logic [N-1:0] ena_q, route_q, sense_q, mode_q;
  logic         pend_clr;

  // line n -> register bit N-1-n
  for (genvar n = 0; n < N; n++) begin : g_rev
    assign src_rev[N-1-n] = src_i[n];
  end

  irq_src_cond #(.N(N)) u_cond (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (src_rev),
    .sense_i (sense_q),
    .mode_i  (mode_q),
    .set_o   (set_vec)
  );

  irq_status_bank #(.N(N)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_en_i   (pend_clr),
    .clr_mask_i (reg_wdata_i),
    .pend_o     (pend_q)
  );

  irq_cfg_regs #(.N(N)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pend_i     (pend_q),
    .ena_o      (ena_q),
    .route_o    (route_q),
    .sense_o    (sense_q),
    .mode_o     (mode_q),
    .pend_clr_o (pend_clr),
    .rdata_o    (reg_rdata_o)
  );

  irq_out_route #(.N(N)) u_out (
    .pend_i     (pend_q),
    .ena_i      (ena_q),
    .route_i    (route_q),
    .irq_o      (irq_o),
    .crit_irq_o (crit_irq_o)
  );
endmodule

// File: rtl/irq_ctrl_slice_chk.sv
module irq_ctrl_slice_chk
  import irq_ctrl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [NUM_SRC-1:0] reg_wdata_i,
  input logic [NUM_SRC-1:0] reg_rdata_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] ena_q,
  input logic [NUM_SRC-1:0] set_vec,
  input logic               irq_o,
  input logic               crit_irq_o
);
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd0) |=> ((pend_q & $past(reg_wdata_i & ~set_vec)) == '0)); // R4

  AST_NO_SILENT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 3'd0) |=> (($past(pend_q) & ~pend_q) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_vec) & ~pend_q) == '0)); // R9

  AST_MASKED_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 3'd5) |-> (reg_rdata_o == (pend_q & ena_q))); // R5

  AST_IRQ_NEEDS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend_q & ena_q) != '0)); // R6

  AST_CRIT_NEEDS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_irq_o |-> ((pend_q & ena_q) != '0)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ena_q) == '0) |-> (!irq_o && !crit_irq_o)); // R6
endmodule

bind irq_ctrl_slice irq_ctrl_slice_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .pend_q      (pend_q),
  .ena_q       (ena_q),
  .set_vec     (set_vec),
  .irq_o       (irq_o),
  .crit_irq_o  (crit_irq_o)
);

// File: tb/irq_ctrl_slice_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, crit;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl_slice dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .crit_irq_o(crit)
  );

  typedef struct packed {
    logic [31:0] sense, ena, route, src, pend, mpend;
    logic        irq, crit;
  } vec_t;

  localparam vec_t TABLE [5] = '{
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0},
    '{32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFE, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1},
    '{32'hFFFF_FFFF, 32'h0F00_0000, 32'h0000_0000, 32'h0000_FF00, 32'h00FF_0000, 32'h0000_0000, 1'b0, 1'b0},
    '{32'h0000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_0000, 32'hFFFF_0000, 32'hFFFF_0000, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    logic [31:0] v;
    rd(3'd0, v); chk({tag, " R10 pending"}, v, 32'h0);
    rd(3'd1, v); chk({tag, " R10 enable"}, v, 32'h0);
    rd(3'd2, v); chk({tag, " R10 routing"}, v, 32'h0);
    rd(3'd3, v); chk({tag, " R10 sense"}, v, 32'hFFFF_FFFF);
    rd(3'd4, v); chk({tag, " R10 mode"}, v, 32'h0);
    chk({tag, " R10 irq_o"}, {31'b0, irq}, 32'h0);
    chk({tag, " R10 crit_irq_o"}, {31'b0, crit}, 32'h0);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);
    check_reset_state("initial");

    // level-mode table, R1 R3 R5 R6 R8
    foreach (TABLE[k]) begin
      wr(3'd4, 32'h0);
      wr(3'd3, TABLE[k].sense);
      wr(3'd1, TABLE[k].ena);
      wr(3'd2, TABLE[k].route);
      src = TABLE[k].src;
      wait_cyc(3);
      wr(3'd0, 32'hFFFF_FFFF);
      wait_cyc(3);
      rd(3'd0, v); chk($sformatf("R1/R3 vec%0d pending", k), v, TABLE[k].pend);
      rd(3'd5, v); chk($sformatf("R5/R8 vec%0d masked", k), v, TABLE[k].mpend);
      chk($sformatf("R6 vec%0d irq_o", k), {31'b0, irq}, {31'b0, TABLE[k].irq});
      chk($sformatf("R6 vec%0d crit_irq_o", k), {31'b0, crit}, {31'b0, TABLE[k].crit});
    end

    // edge mode on line 3 (bit 28)
    src = '0;
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    wait_cyc(3);
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R2 not after one edge", v, 32'h0);
    @(negedge clk);
    rd(3'd0, v); chk("R2 latched after two edges", v, 32'h1000_0000);
    chk("R8 disabled line quiet", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h1000_0000);
    chk("R8 enable raises irq_o", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R4 write zero keeps bit", v, 32'h1000_0000);
    wr(3'd0, 32'h1000_0000);
    wait_cyc(3);
    rd(3'd0, v); chk("R2 edge not re-latched", v, 32'h0);

    // level mode with held source
    wr(3'd4, 32'h0);
    @(negedge clk);
    rd(3'd0, v); chk("R7 level latches", v, 32'h1000_0000);
    wr(3'd0, 32'h1000_0000);
    rd(3'd0, v); chk("R7 level re-sets after ack", v, 32'h1000_0000);

    // falling edge on line 3
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd3, 32'hEFFF_FFFF);
    wait_cyc(2);
    wr(3'd0, 32'hFFFF_FFFF);
    wait_cyc(2);
    rd(3'd0, v); chk("R3 no event while high", v, 32'h0);
    @(negedge clk); src[3] = 1'b0;
    wait_cyc(2);
    rd(3'd0, v); chk("R3 falling edge latched", v, 32'h1000_0000);

    // set and clear in the same cycle
    wr(3'd0, 32'hFFFF_FFFF);
    src[3] = 1'b1;
    wait_cyc(3);
    rd(3'd0, v); chk("R9 pre-clear", v, 32'h0);
    src[3] = 1'b0;
    wr(3'd0, 32'h1000_0000);
    rd(3'd0, v); chk("R9 set beats clear", v, 32'h1000_0000);

    // routing to critical
    wr(3'd2, 32'h1000_0000);
    chk("R6 critical route crit_irq_o", {31'b0, crit}, 32'h1);
    chk("R6 critical route irq_o", {31'b0, irq}, 32'h0);

    // readback and ignored addresses
    wr(3'd1, 32'h1234_5678);
    rd(3'd1, v); chk("R11 enable readback", v, 32'h1234_5678);
    wr(3'd2, 32'hA5A5_A5A5);
    rd(3'd2, v); chk("R11 routing readback", v, 32'hA5A5_A5A5);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R11 masked write ignored", v, 32'h1000_0000);
    rd(3'd1, v); chk("R11 enable untouched", v, 32'h1234_5678);
    rd(3'd6, v); chk("R11 unused address", v, 32'h0);

    // reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    wait_cyc(2);
    rst_ni = 1'b1;
    wait_cyc(1);
    check_reset_state("rerun");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule